// File: doc/BRIEF.md
# CAN Controller Operating-Mode Sequencer

This block owns the 16-bit control word of a CAN controller and the single status flag that confirms the controller sits in reset. Software writes the control word to ask for operation, reset, halt or sleep. The block does not switch at once. It moves the controller to the requested mode only when the hardware is ready. A plain reset or a halt request waits for the bus to be idle between frames. A return to operation waits a fixed number of settling cycles. A forced reset takes effect on the write itself. Software polls the reset-status output to learn when a transition has finished.

The block also guards the controller against a bus fault. When the bus-off recovery field selects automatic halting, a bus-off event during operation sends the controller to halt, and the mode field then reads back as halt. The controller comes out of reset in sleep. While the stored sleep bit is set, mode requests are held off. The fields for bus-off recovery, identifier format, message-lost mode and mailbox mode can change only while the controller is in reset. The protocol engine and the error counters sit outside this block.

Top module: `can_mode_ctrl`

## Requirements
- R1: After reset the control word reads 16'h0500 (sleep bit 10 set, mode field bits 9:8 = 1), `mode_o` is 3 (sleep), and both `rst_stat_o` and `cfg_wr_ok_o` are 0.
- R2: `mode_o` gives the mode that is actually in effect: 0 operation, 1 reset, 2 halt, 3 sleep. The requested mode is the control-word field bits 9:8: 0 operation, 1 reset, 2 halt, 3 forced reset.
- R3: While the stored sleep bit is 1, a write that keeps bit 10 at 1 leaves the mode field unchanged. A write with bit 10 = 0 clears sleep and stores its mode field, and the sequencer then pursues that mode.
- R4: A reset request (field 1) or a halt request (field 2) completes at the first rising edge at which `bus_idle_i` is 1. Until then `mode_o` keeps its previous value.
- R5: A write with field 3 and bit 10 = 0 puts the controller in reset at the clock edge of that write, whatever the state of `bus_idle_i`.
- R6: A request for operation (field 0) completes exactly SETTLE_CYCLES rising edges after the edge that stored it. `mode_o` holds its earlier value until then.
- R7: `rst_stat_o` and `cfg_wr_ok_o` are 1 exactly while the controller is in reset. Each changes only on the edge at which a transition completes.
- R8: The configuration fields (bits 12:11 bus-off recovery, bit 3 message-lost mode, bits 2:1 ID format, bit 0 FIFO mailbox mode) take a write's value only if `cfg_wr_ok_o` was 1 when the write was made. Bits 15:13 and 7:4 always read 0.
- R9: If bits 12:11 = 2'b01 and the controller is in operation, a pulse on `bus_off_i` moves it to halt at the next edge and the mode field reads 2. With any other recovery value the pulse has no effect.
- R10: A write with bit 10 = 1 while the stored sleep bit is 0 puts the controller in sleep at the edge of that write, with `rst_stat_o` = 0.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock, rising edge |
| rst_n | input | 1 | Active-low asynchronous reset |
| wr_en_i | input | 1 | Control-word write strobe |
| wr_data_i | input | 16 | Control-word write value |
| bus_off_i | input | 1 | Bus-off entry event pulse |
| bus_idle_i | input | 1 | Bus idle between frames |
| ctrl_o | output | 16 | Stored control word |
| mode_o | output | 2 | Mode in effect (0 oper, 1 reset, 2 halt, 3 sleep) |
| rst_stat_o | output | 1 | Reset-status flag |
| cfg_wr_ok_o | output | 1 | Configuration fields writable |

## Verification
The transitions are driven with different bus conditions. Reset and halt requests are held while the bus stays busy, which separates a design that waits for idle from one that switches at once. A forced reset is issued with the bus busy, which shows that it bypasses the idle wait. Returns to operation are sampled one cycle before and on the exact settling edge, which catches an off-by-one in the counter. Configuration writes are made both in reset and in operation, and bus-off pulses are given with recovery enabled and disabled, so that filtering by the gate or by the field value shows up at the control-word readback.

// File: rtl/can_mode_pkg.sv
package can_mode_pkg;
   typedef enum logic [1:0] {
      MD_OPER  = 2'd0,
      MD_RESET = 2'd1,
      MD_HALT  = 2'd2,
      MD_SLEEP = 2'd3
   } op_mode_e;

   localparam int CW_W      = 16;
   localparam int SLP_BIT   = 10;
   localparam int REQ_LO    = 8;
   localparam int BOR_LO    = 11;

   localparam logic [1:0] REQ_OPER  = 2'd0;
   localparam logic [1:0] REQ_RESET = 2'd1;
   localparam logic [1:0] REQ_HALT  = 2'd2;
   localparam logic [1:0] REQ_FORCE = 2'd3;
   localparam logic [1:0] BOR_AUTO_HALT = 2'b01;

   localparam logic [CW_W-1:0] CFG_MASK = 16'h180F;
   localparam logic [CW_W-1:0] CW_RST   = 16'h0500;
endpackage

// File: rtl/can_cw_reg.sv
module can_cw_reg
   import can_mode_pkg::*;
(
   input  logic            clk,
   input  logic            rst_n,
   input  logic            wr_en,
   input  logic [CW_W-1:0] wr_data,
   input  logic            cfg_ok,
   input  logic            halt_set,
   input  logic            force_rst,
   output logic [CW_W-1:0] cw_q
);
   logic [CW_W-1:0] cw_d;
   logic            keep_req;

   always_comb begin
      cw_d     = cw_q;
      keep_req = cw_q[SLP_BIT] & wr_data[SLP_BIT];
      if (wr_en) begin
         if (cfg_ok)
            cw_d = (cw_q & ~CFG_MASK) | (wr_data & CFG_MASK);
         cw_d[SLP_BIT] = wr_data[SLP_BIT];
         if (!keep_req)
            cw_d[REQ_LO+:2] = wr_data[REQ_LO+:2];
      end
      if (halt_set && !force_rst)
         cw_d[REQ_LO+:2] = REQ_HALT;
   end

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) cw_q <= CW_RST;
      else        cw_q <= cw_d;
   end
endmodule

// File: rtl/can_mode_seq.sv
module can_mode_seq
   import can_mode_pkg::*;
#(
   parameter int SETTLE_CYCLES = 4,
   localparam int CNT_W = (SETTLE_CYCLES > 1) ? $clog2(SETTLE_CYCLES) : 1
)(
   input  logic       clk,
   input  logic       rst_n,
   input  logic       wr_en,
   input  logic       wr_slp,
   input  logic [1:0] wr_req,
   input  logic       cw_slp,
   input  logic [1:0] cw_req,
   input  logic [1:0] cw_bor,
   input  logic       bus_off,
   input  logic       bus_idle,
   output op_mode_e   mode_q,
   output logic       force_rst,
   output logic       halt_set
);
   op_mode_e mode_d;
   logic     sleep_entry;
   logic     oper_pend;
   logic     settle_done;

   assign force_rst   = wr_en && (wr_req == REQ_FORCE) && !wr_slp;
   assign sleep_entry = wr_en && wr_slp && !cw_slp;
   assign halt_set    = bus_off && (cw_bor == BOR_AUTO_HALT) && (mode_q == MD_OPER);
   assign oper_pend   = !cw_slp && (cw_req == REQ_OPER) && (mode_q != MD_OPER)
                        && !sleep_entry && !force_rst;

   generate
      if (SETTLE_CYCLES == 1) begin : g_no_cnt
         assign settle_done = oper_pend;
      end else begin : g_cnt
         logic [CNT_W-1:0] cnt_q;
         always_ff @(posedge clk or negedge rst_n) begin
            if (!rst_n)          cnt_q <= '0;
            else if (oper_pend && !settle_done) cnt_q <= cnt_q + 1'b1;
            else                 cnt_q <= '0;
         end
         assign settle_done = oper_pend && (cnt_q == CNT_W'(SETTLE_CYCLES - 1));
      end
   endgenerate

   always_comb begin
      mode_d = mode_q;
      if (sleep_entry)      mode_d = MD_SLEEP;
      else if (force_rst)   mode_d = MD_RESET;
      else if (halt_set)    mode_d = MD_HALT;
      else if (!cw_slp) begin
         unique case (cw_req)
            REQ_FORCE: mode_d = MD_RESET;
            REQ_RESET: if (bus_idle) mode_d = MD_RESET;
            REQ_HALT:  if (bus_idle) mode_d = MD_HALT;
            default:   if (settle_done) mode_d = MD_OPER;
         endcase
      end
   end

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) mode_q <= MD_SLEEP;
      else        mode_q <= mode_d;
   end
endmodule

// File: rtl/can_mode_ctrl.sv
module can_mode_ctrl
   import can_mode_pkg::*;
#(
   parameter int SETTLE_CYCLES = 4
)(
   input  logic        clk,
   input  logic        rst_n,
   input  logic        wr_en_i,
   input  logic [15:0] wr_data_i,
   input  logic        bus_off_i,
   input  logic        bus_idle_i,
   output logic [15:0] ctrl_o,
   output logic [1:0]  mode_o,
   output logic        rst_stat_o,
   output logic        cfg_wr_ok_o
);
   generate
      if (SETTLE_CYCLES < 1 || SETTLE_CYCLES > 65535) begin : g_bad_settle
         $error("SETTLE_CYCLES out of range");
      end
   endgenerate

   op_mode_e        mode_q;
   logic            force_rst;
   logic            halt_set;
   logic            in_reset;
   logic [CW_W-1:0] cw_q;

   assign in_reset = (mode_q == MD_RESET);

   can_cw_reg u_reg (
      .clk       (clk),
      .rst_n     (rst_n),
      .wr_en     (wr_en_i),
      .wr_data   (wr_data_i),
      .cfg_ok    (in_reset),
      .halt_set  (halt_set),
      .force_rst (force_rst),
      .cw_q      (cw_q)
   );

   can_mode_seq #(.SETTLE_CYCLES(SETTLE_CYCLES)) u_seq (
      .clk       (clk),
      .rst_n     (rst_n),
      .wr_en     (wr_en_i),
      .wr_slp    (wr_data_i[SLP_BIT]),
      .wr_req    (wr_data_i[REQ_LO+:2]),
      .cw_slp    (cw_q[SLP_BIT]),
      .cw_req    (cw_q[REQ_LO+:2]),
      .cw_bor    (cw_q[BOR_LO+:2]),
      .bus_off   (bus_off_i),
      .bus_idle  (bus_idle_i),
      .mode_q    (mode_q),
      .force_rst (force_rst),
      .halt_set  (halt_set)
   );

   assign ctrl_o      = cw_q;
   assign mode_o      = mode_q;
   assign rst_stat_o  = in_reset;
   assign cfg_wr_ok_o = in_reset;
endmodule

// File: rtl/can_mode_ctrl_chk.sv
module can_mode_ctrl_chk (
   input logic        clk,
   input logic        rst_n,
   input logic        wr_en_i,
   input logic [15:0] wr_data_i,
   input logic        bus_off_i,
   input logic        bus_idle_i,
   input logic [15:0] ctrl_o,
   input logic [1:0]  mode_o,
   input logic        rst_stat_o,
   input logic        cfg_wr_ok_o
);
   // R5: forced reset lands on the write edge
   a_r5_force_now: assert property (@(posedge clk) disable iff (!rst_n)
      (wr_en_i && wr_data_i[9:8] == 2'd3 && !wr_data_i[10]) |=> (mode_o == 2'd1 && rst_stat_o));

   // R9: bus-off with automatic recovery halts the controller
   a_r9_bus_off_halt: assert property (@(posedge clk) disable iff (!rst_n)
      (bus_off_i && ctrl_o[12:11] == 2'b01 && mode_o == 2'd0 && !wr_en_i)
      |=> (mode_o == 2'd2 && ctrl_o[9:8] == 2'd2));

   // R4 / R7: entry into reset needs an idle bus, a forced write or a stored forced request
   a_r4_reset_entry: assert property (@(posedge clk) disable iff (!rst_n)
      $rose(rst_stat_o) |-> ($past(bus_idle_i) || $past(ctrl_o[9:8]) == 2'd3
                             || ($past(wr_en_i) && $past(wr_data_i[9:8]) == 2'd3)));

   // R10 / R3: a stored sleep bit means the controller is asleep
   a_r10_sleep_bit: assert property (@(posedge clk) disable iff (!rst_n)
      ctrl_o[10] |-> (mode_o == 2'd3 && !rst_stat_o));

   // R8: configuration fields stay put when written outside reset
   a_r8_cfg_locked: assert property (@(posedge clk) disable iff (!rst_n)
      ($past(wr_en_i) && !$past(cfg_wr_ok_o))
      |-> (ctrl_o[3:0] == $past(ctrl_o[3:0]) && ctrl_o[12:11] == $past(ctrl_o[12:11])));

   // R8: unused bits never set
   a_r8_spare_zero: assert property (@(posedge clk) disable iff (!rst_n)
      (ctrl_o[15:13] == 3'd0 && ctrl_o[7:4] == 4'd0));

   // R6: operation is entered only on a stored operation request
   a_r6_oper_entry: assert property (@(posedge clk) disable iff (!rst_n)
      $rose(mode_o == 2'd0) |-> ($past(ctrl_o[9:8]) == 2'd0 && !$past(ctrl_o[10])));

   // R7: configuration permission follows the reset status
   a_r7_cfg_tracks: assert property (@(posedge clk) disable iff (!rst_n)
      $rose(cfg_wr_ok_o) |-> mode_o == 2'd1);
endmodule

bind can_mode_ctrl can_mode_ctrl_chk u_chk (
   .clk         (clk),
   .rst_n       (rst_n),
   .wr_en_i     (wr_en_i),
   .wr_data_i   (wr_data_i),
   .bus_off_i   (bus_off_i),
   .bus_idle_i  (bus_idle_i),
   .ctrl_o      (ctrl_o),
   .mode_o      (mode_o),
   .rst_stat_o  (rst_stat_o),
   .cfg_wr_ok_o (cfg_wr_ok_o)
);

// File: tb/can_mode_ctrl_test.sv
`timescale 1ns/1ps
module can_mode_ctrl_test;
   localparam int SETTLE = 4;
   localparam int WD_CYC = 200000;

   logic        clk = 1'b0;
   logic        rst_n = 1'b0;
   logic        wr_en = 1'b0;
   logic [15:0] wr_data = '0;
   logic        bus_off = 1'b0;
   logic        bus_idle = 1'b0;
   logic [15:0] ctrl;
   logic [1:0]  mode;
   logic        rst_stat;
   logic        cfg_ok;

   always #10 clk = ~clk;

   can_mode_ctrl #(.SETTLE_CYCLES(SETTLE)) uut (
      .clk         (clk),
      .rst_n       (rst_n),
      .wr_en_i     (wr_en),
      .wr_data_i   (wr_data),
      .bus_off_i   (bus_off),
      .bus_idle_i  (bus_idle),
      .ctrl_o      (ctrl),
      .mode_o      (mode),
      .rst_stat_o  (rst_stat),
      .cfg_wr_ok_o (cfg_ok)
   );

   typedef struct {
      string       req;
      logic [1:0]  mode;
      logic        stat;
      logic [15:0] ctrl;
   } exp_t;

   exp_t exp_q[$];
   event chk_ev;
   int   n_total = 0;
   int   n_fail  = 0;
   bit   done    = 1'b0;

   // monitor: pops expected items and compares with the outputs
   always @(chk_ev) begin
      while (exp_q.size() > 0) begin
         exp_t e;
         e = exp_q.pop_front();
         n_total++;
         if (mode !== e.mode || rst_stat !== e.stat || cfg_ok !== e.stat || ctrl !== e.ctrl) begin
            n_fail++;
            $display("FAIL %s: mode=%0d stat=%0b cfg=%0b ctrl=%h expected mode=%0d stat=%0b ctrl=%h",
                     e.req, mode, rst_stat, cfg_ok, ctrl, e.mode, e.stat, e.ctrl);
         end
      end
   end

   task automatic expect_st(input string req, input logic [1:0] m, input logic s, input logic [15:0] c);
      exp_t e;
      e.req = req; e.mode = m; e.stat = s; e.ctrl = c;
      exp_q.push_back(e);
      #1;
      -> chk_ev;
      #1;
   endtask

   task automatic cw_write(input logic [15:0] d);
      @(negedge clk);
      wr_en = 1'b1; wr_data = d;
      @(negedge clk);
      wr_en = 1'b0; wr_data = '0;
   endtask

   task automatic idle_pulse();
      @(negedge clk); bus_idle = 1'b1;
      @(negedge clk); bus_idle = 1'b0;
   endtask

   task automatic busoff_pulse();
      @(negedge clk); bus_off = 1'b1;
      @(negedge clk); bus_off = 1'b0;
   endtask

   task automatic wait_cyc(input int n);
      repeat (n) @(negedge clk);
   endtask

   initial begin
      repeat (3) @(negedge clk);
      rst_n = 1'b1;
      @(negedge clk);
      expect_st("R1 reset state", 2'd3, 1'b0, 16'h0500);

      // R3: mode field ignored while sleep stays set
      cw_write(16'h0400);
      expect_st("R3 sleep keeps mode field", 2'd3, 1'b0, 16'h0500);

      // R4: reset request held while the bus is busy
      cw_write(16'h0100);
      expect_st("R3 sleep cleared, still pending", 2'd3, 1'b0, 16'h0100);
      wait_cyc(3);
      expect_st("R4 reset waits for idle", 2'd3, 1'b0, 16'h0100);
      idle_pulse();
      expect_st("R4 reset on idle", 2'd1, 1'b1, 16'h0100);

      // R8: configuration accepted in reset, spare bits dropped
      cw_write(16'hE9FD);
      expect_st("R8 cfg in reset", 2'd1, 1'b1, 16'h090D);

      // R6: settle count to operation
      cw_write(16'h080D);
      wait_cyc(SETTLE - 1);
      expect_st("R6 before settle", 2'd1, 1'b1, 16'h080D);
      wait_cyc(1);
      expect_st("R6 operation after settle", 2'd0, 1'b0, 16'h080D);

      // R8: configuration locked in operation
      cw_write(16'h0802);
      expect_st("R8 cfg locked", 2'd0, 1'b0, 16'h080D);

      // R9: bus-off automatic halt
      busoff_pulse();
      expect_st("R9 bus-off halt", 2'd2, 1'b0, 16'h0A0D);

      // R5: forced reset with bus busy
      cw_write(16'h0B0D);
      expect_st("R5 forced reset", 2'd1, 1'b1, 16'h0B0D);

      // R4: halt waits for idle; R8 recovery field cleared in reset
      cw_write(16'h020D);
      wait_cyc(2);
      expect_st("R4 halt pending", 2'd1, 1'b1, 16'h020D);
      idle_pulse();
      expect_st("R4 halt on idle", 2'd2, 1'b0, 16'h020D);

      // R2: halt to operation
      cw_write(16'h000D);
      wait_cyc(SETTLE);
      expect_st("R2 halt to operation", 2'd0, 1'b0, 16'h000D);

      // R9: recovery field 0 means bus-off has no effect
      busoff_pulse();
      expect_st("R9 bus-off ignored", 2'd0, 1'b0, 16'h000D);

      // R7: status stays low until reset completes
      cw_write(16'h010D);
      wait_cyc(3);
      expect_st("R7 status low while pending", 2'd0, 1'b0, 16'h010D);
      idle_pulse();
      expect_st("R7 status high on completion", 2'd1, 1'b1, 16'h010D);

      // R10: sleep entry
      cw_write(16'h050D);
      expect_st("R10 sleep entry", 2'd3, 1'b0, 16'h050D);

      wait_cyc(2);
      done = 1'b1;
      $display("%0d/%0d checks passed", n_total - n_fail, n_total);
      $finish;
   end

   initial begin
      repeat (WD_CYC) @(posedge clk);
      if (!done) begin
         n_total++;
         n_fail++;
         $display("FAIL watchdog: run did not complete, expected finish before %0d cycles", WD_CYC);
         $display("%0d/%0d checks passed", n_total - n_fail, n_total);
         $finish;
      end
   end
endmodule